// File: doc/BRIEF.md
# SRAM Data-Retention Power-Down Sequencer

This block guards an asynchronous static RAM through supply dips. A supply-good indication, already synchronous to the block clock, tells the sequencer whether the memory supply is inside its normal range. When supply-good is seen low, the sequencer takes over the chosen deselect pins on that same clock edge. It drives them to levels that keep the memory in its low-voltage retention state, where the contents survive a supply as low as 2.0 V. It also raises a hold towards the bus controller, which aborts and stalls any access.

Once supply-good returns, the override stays in place for a fixed recovery window of at least 5 ms, counted in clock cycles. Only when that window expires is the override released and the ready flag raised. Both happen on the same edge. A new dip during the window restarts the whole window.

Three deselect methods are available through a parameter. In byte mode, both byte-lane controls are driven high. In chip-select-1 mode, the active-low chip select is driven high and the active-high chip select is parked at a fixed level. In chip-select-2 mode, the active-high chip select is driven low.

Top module: `sret_top`

## Requirements
- R1: While reset is high, and in the cycle after it, `ready` is 0, `hold` is 1 and the override for the selected mode is applied.
- R2: Byte mode (MODE=SRET_BYTE): while the override is applied, `pin_force` is 4'b0011 and `pin_level` is 4'b0011. Bit 0 is the low byte control, bit 1 the high byte control, bit 2 chip select 1 and bit 3 chip select 2.
- R3: Chip-select-1 mode (MODE=SRET_CS1): while the override is applied, `pin_force` is 4'b1100. Bit 2 of `pin_level` is 1 and bit 3 equals CS2_PARK_HIGH, so with CS2_PARK_HIGH=1 `pin_level` is 4'b1100.
- R4: Chip-select-2 mode (MODE=SRET_CS2): while the override is applied, `pin_force` is 4'b1000 and `pin_level` is 4'b0000.
- R5: At the first rising edge that samples `supply_ok` low, the outputs become: override applied, `hold` 1 and `ready` 0, whatever state the block was in before.
- R6: After `supply_ok` has been sampled high on LOAD consecutive edges, `ready` becomes 1. On that same edge `hold` becomes 0 and `pin_force` becomes 0. After LOAD-1 such edges, `ready` is still 0.
- R7: A low sample of `supply_ok` during the recovery window, even for a single cycle, restarts the full LOAD-cycle window.
- R8: While the override stays applied, `pin_level` does not change. While `ready` is 1, `pin_force` and `pin_level` are 0.
- R9: LOAD equals ceil(HOLD_US * CLK_KHZ / 1000), with a minimum of 1. For example, CLK_KHZ=10 and HOLD_US=5050 give 51.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Memory supply inside its normal range, synchronous to clk |
| pin_force | output | 4 | Per-pin override enable: {cs2, cs1, byte_hi, byte_lo} |
| pin_level | output | 4 | Level to drive on each overridden pin (0 where not forced) |
| hold | output | 1 | Stall/abort request to the bus controller |
| ready | output | 1 | Memory may be accessed |

## Verification
A recovery counter that loads the wrong value, or that does not reload on a dip, shows up as `ready` rising too early or too late. The error is visible on the exact edge where the window should close, so the bench counts edges from the supply return and samples both sides of that edge. A mode decode error shows up as a wrong `pin_force` or `pin_level` pattern one edge after a dip. A pin-override flop that sticks shows up as a nonzero override while `ready` is high, on the first cycle after release.

// File: rtl/sret_pkg.sv
package sret_pkg;

  typedef enum logic [1:0] {
    SRET_BYTE = 2'd0,
    SRET_CS1  = 2'd1,
    SRET_CS2  = 2'd2
  } sret_mode_e;

  localparam int PIN_N     = 4;
  localparam int PIN_BC_LO = 0;
  localparam int PIN_BC_HI = 1;
  localparam int PIN_CS1   = 2;
  localparam int PIN_CS2   = 3;

  // Which pins a mode takes over.
  function automatic logic [PIN_N-1:0] force_mask(sret_mode_e m);
    logic [PIN_N-1:0] r;
    r = '0;
    case (m)
      SRET_BYTE: begin r[PIN_BC_LO] = 1'b1; r[PIN_BC_HI] = 1'b1; end
      SRET_CS1:  begin r[PIN_CS1] = 1'b1; r[PIN_CS2] = 1'b1; end
      SRET_CS2:  r[PIN_CS2] = 1'b1;
      default:   r = '0;
    endcase
    return r;
  endfunction

  // Level driven on each taken-over pin during retention.
  function automatic logic [PIN_N-1:0] force_level(sret_mode_e m, logic park_high);
    logic [PIN_N-1:0] r;
    r = '0;
    case (m)
      SRET_BYTE: begin r[PIN_BC_LO] = 1'b1; r[PIN_BC_HI] = 1'b1; end
      SRET_CS1:  begin r[PIN_CS1] = 1'b1; r[PIN_CS2] = park_high; end
      SRET_CS2:  r[PIN_CS2] = 1'b0;
      default:   r = '0;
    endcase
    return r;
  endfunction

  // Recovery window in clock cycles, rounded up, never below one.
  function automatic int unsigned recovery_cycles(int unsigned khz, int unsigned us);
    longint unsigned p;
    p = (longint'(khz) * longint'(us) + 64'd999) / 64'd1000;
    if (p < 64'd1) p = 64'd1;
    return int'(p);
  endfunction

endpackage

// File: rtl/sret_timer.sv
module sret_timer #(
  parameter int unsigned LOAD = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic open_d
);
  localparam int CW = $clog2(LOAD + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)
      cnt_d = CW'(LOAD);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
    else
      cnt_d = '0;
  end

  // Window closes on the edge where the count reaches zero.
  assign open_d = run && (cnt_q <= CW'(1));

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= CW'(LOAD);
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sret_ctrl.sv
module sret_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic open_d,
  output logic ready,
  output logic hold
);
  logic ready_q, hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      hold_q  <= 1'b1;
    end else begin
      ready_q <= open_d;
      hold_q  <= !open_d;
    end
  end

  assign ready = ready_q;
  assign hold  = hold_q;
endmodule

// File: rtl/sret_pinmap.sv
module sret_pinmap #(
  parameter logic [3:0] MASK  = 4'b0011,
  parameter logic [3:0] LEVEL = 4'b0011
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       open_d,
  output logic [3:0] pin_force,
  output logic [3:0] pin_level
);
  logic apply_d;
  assign apply_d = rst || !open_d;

  for (genvar i = 0; i < 4; i++) begin : g_pin
    if (MASK[i]) begin : g_taken
      logic f_q, l_q;
      always_ff @(posedge clk) begin
        f_q <= apply_d;
        l_q <= apply_d ? LEVEL[i] : 1'b0;
      end
      assign pin_force[i] = f_q;
      assign pin_level[i] = l_q;
    end else begin : g_free
      assign pin_force[i] = 1'b0;
      assign pin_level[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sret_top.sv
module sret_top #(
  parameter int unsigned          CLK_KHZ       = 50000,
  parameter int unsigned          HOLD_US       = 5000,
  parameter sret_pkg::sret_mode_e MODE          = sret_pkg::SRET_BYTE,
  parameter bit                   CS2_PARK_HIGH = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok,
  output logic [3:0] pin_force,
  output logic [3:0] pin_level,
  output logic       hold,
  output logic       ready
);
  localparam int unsigned LOAD_CYC   = sret_pkg::recovery_cycles(CLK_KHZ, HOLD_US);
  localparam logic [3:0]  FORCE_MASK = sret_pkg::force_mask(MODE);
  localparam logic [3:0]  FORCE_LVL  = sret_pkg::force_level(MODE, CS2_PARK_HIGH);

  logic open_d;

  sret_timer #(.LOAD(LOAD_CYC)) u_timer (
    .clk(clk), .rst(rst), .run(supply_ok), .open_d(open_d)
  );

  sret_ctrl u_ctrl (
    .clk(clk), .rst(rst), .open_d(open_d), .ready(ready), .hold(hold)
  );

  sret_pinmap #(.MASK(FORCE_MASK), .LEVEL(FORCE_LVL)) u_pins (
    .clk(clk), .rst(rst), .open_d(open_d),
    .pin_force(pin_force), .pin_level(pin_level)
  );
endmodule

// File: rtl/sret_checker.sv
module sret_checker #(
  parameter int unsigned LOAD      = 1,
  parameter logic [3:0]  EXP_FORCE = 4'b0011
) (
  input logic       clk,
  input logic       rst,
  input logic       supply_ok,
  input logic [3:0] pin_force,
  input logic [3:0] pin_level,
  input logic       hold,
  input logic       ready
);
  logic [31:0] win_q;

  always_ff @(posedge clk) begin
    if (rst || !supply_ok) win_q <= '0;
    else if (win_q != 32'hFFFF_FFFF) win_q <= win_q + 32'd1;
  end

  assert_drop_forces_R5: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (!ready && hold && pin_force == EXP_FORCE));

  assert_hold_tracks_R6: assert property (@(posedge clk) disable iff (rst)
    hold == !ready);

  assert_window_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (win_q >= LOAD));

  assert_mode_mask_R2: assert property (@(posedge clk) disable iff (rst)
    (pin_force == 4'b0000) || (pin_force == EXP_FORCE));

  assert_released_R8: assert property (@(posedge clk) disable iff (rst)
    ready |-> (pin_force == 4'b0000 && pin_level == 4'b0000));

  assert_level_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (pin_force != 4'b0000 && $past(pin_force != 4'b0000)) |-> $stable(pin_level));
endmodule

bind sret_top sret_checker #(.LOAD(LOAD_CYC), .EXP_FORCE(FORCE_MASK)) u_chk (
  .clk(clk), .rst(rst), .supply_ok(supply_ok), .pin_force(pin_force),
  .pin_level(pin_level), .hold(hold), .ready(ready)
);

// File: tb/test_sret_top.sv
module test_sret_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOAD_A     = 50;   // 10 kHz * 5000 us
  localparam int LOAD_B     = 51;   // 10 kHz * 5050 us, rounded up

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b1;
  logic [3:0] f_b, l_b, f_1, l_1, f_2, l_2;
  logic h_b, r_b, h_1, r_1, h_2, r_2;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sret_top #(.CLK_KHZ(10), .HOLD_US(5000), .MODE(sret_pkg::SRET_BYTE)) i_sret_top (
    .clk(clk), .rst(rst), .supply_ok(supply_ok),
    .pin_force(f_b), .pin_level(l_b), .hold(h_b), .ready(r_b));

  sret_top #(.CLK_KHZ(10), .HOLD_US(5050), .MODE(sret_pkg::SRET_CS1),
             .CS2_PARK_HIGH(1'b1)) i_sret_top_cs1 (
    .clk(clk), .rst(rst), .supply_ok(supply_ok),
    .pin_force(f_1), .pin_level(l_1), .hold(h_1), .ready(r_1));

  sret_top #(.CLK_KHZ(10), .HOLD_US(5000), .MODE(sret_pkg::SRET_CS2)) i_sret_top_cs2 (
    .clk(clk), .rst(rst), .supply_ok(supply_ok),
    .pin_force(f_2), .pin_level(l_2), .hold(h_2), .ready(r_2));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_forced(input string req);
    check({req, " byte force"}, 32'(f_b), 32'h3);
    check({req, " byte level"}, 32'(l_b), 32'h3);
    check({req, " cs1 force"},  32'(f_1), 32'hC);
    check({req, " cs1 level"},  32'(l_1), 32'hC);
    check({req, " cs2 force"},  32'(f_2), 32'h8);
    check({req, " cs2 level"},  32'(l_2), 32'h0);
    check({req, " hold"}, 32'({h_b, h_1, h_2}), 32'h7);
    check({req, " ready"}, 32'({r_b, r_1, r_2}), 32'h0);
  endtask

  // R1, R6, R9
  task automatic t_reset;
    rst = 1'b1; supply_ok = 1'b1;
    step(3);
    check_forced("R1 in reset");
    rst = 1'b0;
    step(LOAD_A - 1);
    check("R6 not ready at LOAD-1", 32'({r_b, r_1, r_2}), 32'h0);
    step(1);
    check("R6 byte ready at LOAD", 32'(r_b), 32'h1);
    check("R6 byte hold released", 32'(h_b), 32'h0);
    check("R8 byte force released", 32'({f_b, l_b}), 32'h0);
    check("R6 cs2 ready at LOAD", 32'(r_2), 32'h1);
    check("R9 cs1 not ready at 50", 32'(r_1), 32'h0);
    step(1);
    check("R9 cs1 ready at 51", 32'(r_1), 32'h1);
    check("R8 cs1 force released", 32'({f_1, l_1}), 32'h0);
  endtask

  // R2, R3, R4, R5, R8
  task automatic t_drop;
    supply_ok = 1'b0;
    step(1);
    check_forced("R5 R2 R3 R4 after drop");
    step(10);
    check_forced("R8 held during dip");
  endtask

  // R7: partial recovery then a new dip
  task automatic t_restart;
    supply_ok = 1'b1;
    step(20);
    check("R7 mid window", 32'({r_b, r_1, r_2}), 32'h0);
    supply_ok = 1'b0;
    step(1);
    check_forced("R7 redip");
    supply_ok = 1'b1;
    step(LOAD_A - 1);
    check("R7 restarted window", 32'({r_b, r_2}), 32'h0);
    step(1);
    check("R7 byte ready after full window", 32'(r_b), 32'h1);
    step(1);
    check("R7 cs1 ready after full window", 32'(r_1), 32'h1);
  endtask

  // R5, R7: one-cycle glitch while running
  task automatic t_glitch;
    supply_ok = 1'b0;
    step(1);
    supply_ok = 1'b1;
    check_forced("R5 glitch");
    step(1);
    check("R7 still held after glitch", 32'({h_b, h_1, h_2}), 32'h7);
    step(LOAD_A - 2);
    check("R7 glitch window LOAD-1", 32'(r_b), 32'h0);
    step(1);
    check("R7 glitch window LOAD", 32'({r_b, r_2}), 32'h3);
    check("R8 released after glitch", 32'({f_b, f_2}), 32'h0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 5000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(1);
    t_reset();
    t_drop();
    t_restart();
    t_glitch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule